// File: doc/BRIEF.md
# Low-Frequency Tag Load-Modulation Playback Engine

This block makes a passive low-frequency tag out of a stored bit pattern. A reader carrier clock, sampled from the antenna front end, paces the playback. On each high phase of that carrier the engine looks up the current pattern bit and sets an antenna load switch. A 1 leaves the coil open and a 0 shorts it. The pattern index moves forward only after the carrier has gone low again. The pattern is held in an external synchronous one-bit-wide memory, and the engine drives that memory's address.

Playback starts on a start pulse. At that moment the engine captures the pattern length, the gap length and the indicator-enable input. It then loops over the pattern with no end. If the captured gap length is nonzero, each wrap of the pattern is followed by a stretch of shorted coil that lasts that many system clock cycles. A stop request returns the engine to the off state from any playback phase.

The carrier input passes through a two-flop synchronizer before it is used. So the coil responds a few system cycles after each carrier transition. The carrier must be much slower than the system clock.

Top module: `lf_playback_engine`

## Requirements
- R1: Out of reset, busy is low, the coil line is high (coil open, off state), the activity indicator is low and the memory address is 0.
- R2: A start pulse with a pattern length of 0 is ignored, and busy stays low.
- R3: During playback, once the synchronized carrier is seen high, the coil line takes the value of the current pattern bit: 1 means coil open (line high) and 0 means coil shorted (line low).
- R4: The pattern index increments by one only after the coil has been set for a high phase and the synchronized carrier is then seen low. Pattern entries are therefore played in address order, one per full carrier cycle.
- R5: When the index reaches the captured pattern length, it wraps to 0 and playback repeats with no end.
- R6: At a wrap with a nonzero captured gap length G, the coil line is held low for G system cycles. After that the engine waits for the carrier to be high and resumes at index 0.
- R7: With a captured gap length of 0, no shorted interval is inserted at the wrap. The coil keeps its last value until the next high phase.
- R8: A stop request during any playback phase ends playback on the next clock edge: busy goes low, the coil line goes high and the indicator goes low. A stop request while idle has no effect.
- R9: The activity indicator is high during playback if and only if the indicator-enable input was high at start.
- R10: While busy, the memory address is always below the captured pattern length. Lengths above the memory depth are clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | Sampled reader carrier clock, asynchronous |
| start_i | input | 1 | One-cycle start pulse |
| stop_i | input | 1 | Stop request |
| ind_en_i | input | 1 | Enables the activity indicator for this run, captured at start |
| pat_len_i | input | LEN_W | Pattern length in entries, captured at start |
| gap_len_i | input | GAP_W | Shorted gap after each wrap, in system cycles, captured at start |
| mem_addr_o | output | AW | Pattern memory read address |
| mem_data_i | input | 1 | Pattern bit, one cycle after the address |
| coil_open_o | output | 1 | 1 = coil open, 0 = coil shorted |
| busy_o | output | 1 | Playback in progress |
| active_o | output | 1 | Activity indicator |

## Verification
The embedded assertions check the following on every cycle: the shorted coil throughout the gap, the return to the off state one edge after a stop, an address that stays inside the captured length, index moves that happen only after a low carrier level, and a coil value that equals the memory bit read in the high phase. Some behaviour can only be shown by the bench's scenarios, because it depends on sequences of many carrier cycles. These are the played order of whole patterns across several wraps, the exact length of the gap relative to the carrier edge that triggered it, the resumption at entry 0, and the indicator state for each enable setting.

// File: rtl/lfpb_pkg.sv
package lfpb_pkg;

    typedef enum logic [1:0] {
        PB_IDLE    = 2'd0,
        PB_WAIT_HI = 2'd1,
        PB_WAIT_LO = 2'd2,
        PB_GAP     = 2'd3
    } pb_state_e;

endpackage

// File: rtl/lfpb_sync.sv
module lfpb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lfpb_seq.sv
module lfpb_seq
    import lfpb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int GAP_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             car_s,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             ind_en_i,
    input  logic [LEN_W-1:0] pat_len_i,
    input  logic [GAP_W-1:0] gap_len_i,
    input  logic             mem_data_i,
    output logic [AW-1:0]    mem_addr_o,
    output logic             coil_open_o,
    output logic             busy_o,
    output logic             active_o
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);

    typedef struct packed {
        pb_state_e        st;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] cnt;
        logic             coil;
        logic             ind;
        logic             rd_ok;
    } seq_t;

    seq_t q, d;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] idx_inc;

    assign len_eff = (pat_len_i > MAX_LEN) ? MAX_LEN : pat_len_i;
    assign idx_inc = q.idx + 1'b1;

    always_comb begin
        d = q;
        unique case (q.st)
            PB_IDLE: begin
                d.coil = 1'b1;
                d.ind  = 1'b0;
                if (start_i && !stop_i && (len_eff != '0)) begin
                    d.st  = PB_WAIT_HI;
                    d.idx = '0;
                    d.len = len_eff;
                    d.gap = gap_len_i;
                    d.ind = ind_en_i;
                end
            end
            PB_WAIT_HI: begin
                if (car_s && q.rd_ok) begin
                    d.coil = mem_data_i;
                    d.st   = PB_WAIT_LO;
                end
            end
            PB_WAIT_LO: begin
                if (!car_s) begin
                    if (idx_inc == q.len) begin
                        d.idx = '0;
                        if (q.gap != '0) begin
                            d.st   = PB_GAP;
                            d.cnt  = q.gap;
                            d.coil = 1'b0;
                        end else begin
                            d.st = PB_WAIT_HI;
                        end
                    end else begin
                        d.idx = idx_inc;
                        d.st  = PB_WAIT_HI;
                    end
                end
            end
            PB_GAP: begin
                d.coil = 1'b0;
                if (q.cnt <= 1) d.st = PB_WAIT_HI;
                else            d.cnt = q.cnt - 1'b1;
            end
            default: d.st = PB_IDLE;
        endcase
        if (stop_i && (q.st != PB_IDLE)) begin
            d.st   = PB_IDLE;
            d.coil = 1'b1;
            d.ind  = 1'b0;
        end
        d.rd_ok = (d.idx == q.idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= PB_IDLE;
            q.coil  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o  = q.idx[AW-1:0];
    assign coil_open_o = q.coil;
    assign busy_o      = (q.st != PB_IDLE);
    assign active_o    = q.ind;

    // R6
    gap_shorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PB_GAP) |-> !coil_open_o);

    // R8
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |=> (!busy_o && coil_open_o && !active_o));

    // R10
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.idx < q.len));

    // R4
    advance_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.st) == PB_WAIT_LO) && (q.idx != $past(q.idx))) |-> !$past(car_s));

    // R3
    coil_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.st) == PB_WAIT_HI) && (q.st == PB_WAIT_LO)) |-> (coil_open_o == $past(mem_data_i)));

    // R9
    ind_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> busy_o);

    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (pat_len_i == '0)) |=> !busy_o);
endmodule

// File: rtl/lf_playback_engine.sv
module lf_playback_engine #(
    parameter int DEPTH = 64,
    parameter int GAP_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_in,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             ind_en_i,
    input  logic [LEN_W-1:0] pat_len_i,
    input  logic [GAP_W-1:0] gap_len_i,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_data_i,
    output logic             coil_open_o,
    output logic             busy_o,
    output logic             active_o
);
    logic car_s;

    lfpb_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (carrier_in),
        .sync_o  (car_s)
    );

    lfpb_seq #(.DEPTH(DEPTH), .GAP_W(GAP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .car_s       (car_s),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .ind_en_i    (ind_en_i),
        .pat_len_i   (pat_len_i),
        .gap_len_i   (gap_len_i),
        .mem_data_i  (mem_data_i),
        .mem_addr_o  (mem_addr_o),
        .coil_open_o (coil_open_o),
        .busy_o      (busy_o),
        .active_o    (active_o)
    );
endmodule

// File: tb/lf_playback_engine_bench.sv
module lf_playback_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int GAP_W = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam int HALF  = 8;
    localparam int NV    = 4;

    localparam logic [15:0] V_PAT [NV] = '{16'hB5A3, 16'h0001, 16'h0001, 16'h0006};
    localparam int          V_LEN [NV] = '{16, 5, 1, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier = 1'b0;
    logic start = 1'b0;
    logic stop = 1'b0;
    logic ind_en = 1'b0;
    logic [LEN_W-1:0] pat_len = '0;
    logic [GAP_W-1:0] gap_len = '0;
    logic [AW-1:0] mem_addr;
    logic mem_data;
    logic coil_open, busy, active;
    logic mem [DEPTH];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) mem_data <= mem[mem_addr];

    lf_playback_engine #(.DEPTH(DEPTH), .GAP_W(GAP_W)) u_lf_playback_engine (
        .clk(clk), .rst_n(rst_n), .carrier_in(carrier), .start_i(start),
        .stop_i(stop), .ind_en_i(ind_en), .pat_len_i(pat_len), .gap_len_i(gap_len),
        .mem_addr_o(mem_addr), .mem_data_i(mem_data), .coil_open_o(coil_open),
        .busy_o(busy), .active_o(active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic carrier_cycle(output logic hi_s, output logic lo_s);
        carrier = 1'b1;
        repeat (HALF) @(negedge clk);
        hi_s = coil_open;
        carrier = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        lo_s = coil_open;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic load_pat(input logic [15:0] p);
        for (int i = 0; i < DEPTH; i++) mem[i] = (i < 16) ? p[i] : 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic hi, lo;
        load_pat(16'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 coil", coil_open, 1);
        chk("R1 active", active, 0);
        chk("R1 addr", mem_addr, 0);

        // R2 zero length start ignored
        pat_len = '0;
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R2 busy", busy, 0);

        // R8 stop while idle has no effect
        pulse_stop();
        chk("R8 idle stop busy", busy, 0);
        chk("R8 idle stop coil", coil_open, 1);

        // table walk: gap 0 playback
        for (int v = 0; v < NV; v++) begin
            load_pat(V_PAT[v]);
            pat_len = LEN_W'(V_LEN[v]);
            gap_len = '0;
            ind_en  = v[0];
            pulse_start();
            repeat (3) @(negedge clk);
            chk("R9 active", active, v[0]);
            for (int k = 0; k < 2 * V_LEN[v] + 3; k++) begin
                carrier_cycle(hi, lo);
                if (k < V_LEN[v]) chk("R3 R4 bit", hi, V_PAT[v][k]);
                else              chk("R5 wrap bit", hi, V_PAT[v][k % V_LEN[v]]);
                if (v == 2)       chk("R7 no gap", lo, 1);
            end
            pulse_stop();
            repeat (3) @(negedge clk);
        end

        // R8 stop mid pattern
        load_pat(16'hB5A3);
        pat_len = 16;
        ind_en = 1'b1;
        pulse_start();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 5; k++) carrier_cycle(hi, lo);
        chk("R9 active on", active, 1);
        pulse_stop();
        chk("R8 stop busy", busy, 0);
        chk("R8 stop coil", coil_open, 1);
        chk("R8 stop active", active, 0);

        // R6 gap after wrap: pattern 1,0,1 with gap of 20 cycles
        load_pat(16'h0005);
        pat_len = 3;
        gap_len = 20;
        ind_en = 1'b0;
        pulse_start();
        repeat (3) @(negedge clk);
        carrier_cycle(hi, lo); chk("R3 gap run b0", hi, 1);
        carrier_cycle(hi, lo); chk("R3 gap run b1", hi, 0);
        carrier = 1'b1;
        repeat (HALF) @(negedge clk);
        chk("R3 gap run b2", coil_open, 1);
        carrier = 1'b0;
        repeat (HALF) @(negedge clk);
        carrier = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6 gap shorted", coil_open, 0);
        chk("R6 busy in gap", busy, 1);
        repeat (6) @(negedge clk);
        chk("R6 resume idx0", coil_open, 1);
        carrier = 1'b0;
        repeat (HALF) @(negedge clk);
        carrier_cycle(hi, lo); chk("R6 resume b1", hi, 0);
        carrier_cycle(hi, lo); chk("R6 resume b2", hi, 1);
        pulse_stop();
        chk("R8 stop after gap", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule